// File: doc/BRIEF.md
# Dual-Rail I/O Compensation Code Selector

This block chooses the 8-bit drive-strength code (a 4-bit PMOS half above a 4-bit NMOS half) for each of two separate I/O supply rails. Each rail can take its code from one of three places: the live value tracked by its compensation cell, an override code written by software, or a fixed default. Which one applies depends on the rail's select bit, on whether the cell has produced a value, and on the chip's low-power mode.

Each rail has its own enable, select and ready flag. The analog cell is modelled by value inputs, a per-rail settle strobe and a high-speed-clock-present input. A rail reports ready a parameterised number of clocks after its cell becomes active. The settled value is captured on a strobe and stays readable after the cell is switched off, so software can copy it into the override word and then power the cell down. A small word-addressed register port gives access to the control/status word (index 0), the read-only value word (index 1) and the override code word (index 2). Other indices read as zero.

Top module: `iocomp_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x0000000A, the override word reads 0x00007878 and the value word reads 0x00000000.
- R2: In the control/status word, bit 0 enables rail 1, bit 1 is the rail 1 select, bit 2 enables rail 2 and bit 3 is the rail 2 select. All four are read/write. Bit 8 is the rail 1 ready flag and bit 9 is the rail 2 ready flag, and both are read-only.
- R3: A rail's ready flag is set only while its cell is active and hsclk_ok_i is high. It reads 1 starting READY_DLY clocks after the cell becomes active, and reads 0 on every earlier cycle.
- R4: A ready flag reads 0 starting in the first cycle after the enable bit is written to 0.
- R5: The value word holds rail 2 PMOS in bits 15:12, rail 2 NMOS in 11:8, rail 1 PMOS in 7:4 and rail 1 NMOS in 3:0. A rail's field reads 0 until a settle strobe arrives while that rail is ready. On each such strobe the field loads the cell input. The field keeps its last value after the rail is disabled.
- R6: When a rail's select bit is 1, the rail applies its override code. When the select bit is 0, it applies its captured cell value if one exists, and FIXED_CODE otherwise. rail_code_o uses the same layout as the value word.
- R7: In standby mode (lp_mode_i = 3), both rails apply FIXED_CODE, both cell enables are low and both ready flags are clear.
- R8: In stop mode (lp_mode_i = 2), rail 1's cell follows its enable bit and rail 2's cell is held disabled. Run (0) and sleep (1) leave both cells under their enable bits.
- R9: The override word is read/write with the value-word layout. Writes to the value word, to the ready bits and to unmapped indices change no state.
- R10: cell_en_o[r] is high exactly when rail r's enable bit is set and the mode permits that rail's cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word index: 0 control/status, 1 value, 2 override |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| lp_mode_i | input | 2 | 0 run, 1 sleep, 2 stop, 3 standby |
| hsclk_ok_i | input | 1 | High-speed clock present |
| cell_val_i | input | 16 | Cell values, value-word layout |
| cell_settle_i | input | 2 | Per-rail settle strobe (bit 0 rail 1) |
| cell_en_o | output | 2 | Per-rail cell enable |
| rail_code_o | output | 16 | Applied codes, value-word layout |

## Verification
The bench builds the block with READY_DLY = 3 and FIXED_CODE = 0x5A. The short delay lets it check the cycle just before the ready edge and the ready edge itself within a few clocks. Because 0x5A differs from the 0x78 override reset code, a fallback to the default code can be told apart from an applied override. The stop and standby cases run after both rails hold distinct captured and override codes, so a wrong choice among the three sources shows up on rail_code_o.

// File: rtl/iocomp_pkg.sv
package iocomp_pkg;
  localparam int NRAIL  = 2;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 2 * NIB_W;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 2;
  localparam int RDY_LSB = 8;

  typedef enum logic [1:0] {
    LP_RUN     = 2'd0,
    LP_SLEEP   = 2'd1,
    LP_STOP    = 2'd2,
    LP_STANDBY = 2'd3
  } lp_mode_e;

  typedef struct packed {
    logic cs;
    logic en;
  } rail_ctl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_VAL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_OVR  = 2'd2;
endpackage

// File: rtl/iocomp_rail.sv
module iocomp_rail
  import iocomp_pkg::*;
#(
  parameter int                READY_DLY  = 8,
  parameter logic [CODE_W-1:0] FIXED_CODE = 8'h78,
  parameter bit                STOP_KEEPS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs_i,
  input  logic [1:0]        lp_mode_i,
  input  logic              hsclk_ok_i,
  input  logic [CODE_W-1:0] cell_val_i,
  input  logic              settle_i,
  input  logic [CODE_W-1:0] ovr_code_i,
  output logic              cell_en_o,
  output logic              rdy_o,
  output logic [CODE_W-1:0] val_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = ($clog2(READY_DLY + 1) > 0) ? $clog2(READY_DLY + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(READY_DLY);

  logic              mode_ok, live, standby;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] cap_q;
  logic              valid_q;

  assign standby = (lp_mode_i == LP_STANDBY);

  always_comb begin
    unique case (lp_mode_i)
      LP_STANDBY: mode_ok = 1'b0;
      LP_STOP:    mode_ok = STOP_KEEPS;
      default:    mode_ok = 1'b1;
    endcase
  end

  assign cell_en_o = en_i & mode_ok;
  assign live      = cell_en_o & hsclk_ok_i;
  assign rdy_o     = live && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!live)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // capture settled value; held once valid, even after disable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      valid_q <= 1'b0;
    end else if (rdy_o && settle_i) begin
      cap_q   <= cell_val_i;
      valid_q <= 1'b1;
    end
  end

  assign val_o = valid_q ? cap_q : '0;

  always_comb begin
    if (standby)      code_o = FIXED_CODE;
    else if (cs_i)    code_o = ovr_code_i;
    else if (valid_q) code_o = cap_q;
    else              code_o = FIXED_CODE;
  end

  AST_RDY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (hsclk_ok_i && en_i && !standby)); // R3
  AST_RDY_PRIOR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(live)); // R3
  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> !rdy_o); // R4
  AST_VAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rdy_o && settle_i) |=> $stable(val_o)); // R5
  AST_STANDBY_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby |-> (code_o == FIXED_CODE && !cell_en_o)); // R7
endmodule

// File: rtl/iocomp_regs.sv
module iocomp_regs
  import iocomp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [WORD_W-1:0]       reg_wdata_i,
  output logic [WORD_W-1:0]       reg_rdata_o,
  input  logic [NRAIL-1:0]        rdy_i,
  input  logic [NRAIL*CODE_W-1:0] val_i,
  output rail_ctl_t [NRAIL-1:0]   ctl_o,
  output logic [NRAIL*CODE_W-1:0] ovr_o
);
  localparam int CTL_W = 2 * NRAIL;
  localparam logic [CTL_W-1:0]        CTL_RST = {NRAIL{2'b10}};
  localparam logic [NRAIL*CODE_W-1:0] OVR_RST = {NRAIL{8'h78}};

  rail_ctl_t [NRAIL-1:0]   ctl_q;
  logic [NRAIL*CODE_W-1:0] ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_RST;
      ovr_q <= OVR_RST;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CTRL:  ctl_q <= reg_wdata_i[CTL_W-1:0];
        A_OVR:   ovr_q <= reg_wdata_i[NRAIL*CODE_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctl_o = ctl_q;
  assign ovr_o = ovr_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CTL_W-1:0]               = ctl_q;
        reg_rdata_o[RDY_LSB +: NRAIL]        = rdy_i;
      end
      A_VAL:   reg_rdata_o[NRAIL*CODE_W-1:0] = val_i;
      A_OVR:   reg_rdata_o[NRAIL*CODE_W-1:0] = ovr_q;
      default: reg_rdata_o = '0;
    endcase
  end

  AST_RO_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i != A_CTRL && reg_addr_i != A_OVR)
      |=> ($stable(ctl_q) && $stable(ovr_q))); // R9
  AST_OVR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == A_OVR)
      |=> (ovr_q == $past(reg_wdata_i[NRAIL*CODE_W-1:0]))); // R9
endmodule

// File: rtl/iocomp_ctrl.sv
module iocomp_ctrl
  import iocomp_pkg::*;
#(
  parameter int                READY_DLY  = 8,
  parameter logic [CODE_W-1:0] FIXED_CODE = 8'h78
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [WORD_W-1:0]       reg_wdata_i,
  output logic [WORD_W-1:0]       reg_rdata_o,
  input  logic [1:0]              lp_mode_i,
  input  logic                    hsclk_ok_i,
  input  logic [NRAIL*CODE_W-1:0] cell_val_i,
  input  logic [NRAIL-1:0]        cell_settle_i,
  output logic [NRAIL-1:0]        cell_en_o,
  output logic [NRAIL*CODE_W-1:0] rail_code_o
);
  rail_ctl_t [NRAIL-1:0]   ctl;
  logic [NRAIL*CODE_W-1:0] ovr, val;
  logic [NRAIL-1:0]        rdy;

  iocomp_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .rdy_i       (rdy),
    .val_i       (val),
    .ctl_o       (ctl),
    .ovr_o       (ovr)
  );

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    // only the first rail keeps its cell in stop mode
    iocomp_rail #(
      .READY_DLY  (READY_DLY),
      .FIXED_CODE (FIXED_CODE),
      .STOP_KEEPS (r == 0)
    ) u_rail (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ctl[r].en),
      .cs_i       (ctl[r].cs),
      .lp_mode_i  (lp_mode_i),
      .hsclk_ok_i (hsclk_ok_i),
      .cell_val_i (cell_val_i[r*CODE_W +: CODE_W]),
      .settle_i   (cell_settle_i[r]),
      .ovr_code_i (ovr[r*CODE_W +: CODE_W]),
      .cell_en_o  (cell_en_o[r]),
      .rdy_o      (rdy[r]),
      .val_o      (val[r*CODE_W +: CODE_W]),
      .code_o     (rail_code_o[r*CODE_W +: CODE_W])
    );

    AST_OVR_APPLIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl[r].cs && lp_mode_i != LP_STANDBY)
        |-> (rail_code_o[r*CODE_W +: CODE_W] == ovr[r*CODE_W +: CODE_W])); // R6
  end

  AST_STOP_RAIL2_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i == LP_STOP) |-> (!cell_en_o[1] && !rdy[1])); // R8
  AST_EN_FOLLOWS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_mode_i != LP_STANDBY) |-> (cell_en_o[0] == ctl[0].en)); // R10
endmodule

// File: tb/iocomp_ctrl_bench.sv
module iocomp_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  mode = 2'd0;
  logic        hsclk = 1'b1;
  logic [15:0] cval = '0;
  logic [1:0]  settle = '0;
  logic [1:0]  cen;
  logic [15:0] code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  iocomp_ctrl #(.READY_DLY(3), .FIXED_CODE(8'h5A)) u_iocomp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lp_mode_i(mode),
    .hsclk_ok_i(hsclk), .cell_val_i(cval), .cell_settle_i(settle),
    .cell_en_o(cen), .rail_code_o(code)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_settle(logic [1:0] s, logic [15:0] v);
    @(negedge clk);
    settle = s; cval = v;
    @(negedge clk);
    settle = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 2'd0, 32'h0000000A);
    rd_chk("R1 ovr", 2'd2, 32'h00007878);
    rd_chk("R1 val", 2'd1, 32'h0);
    chk("R6 reset code", {16'h0, code}, 32'h7878);
    chk("R10 reset cell_en", {30'h0, cen}, 32'h0);
  endtask

  task automatic t_ready_rail1();
    wr_reg(2'd0, 32'h9); // en1, cs1=0, cs2=1
    chk("R10 cell_en rail1", {30'h0, cen}, 32'h1);
    chk("R6 no value -> fixed", {16'h0, code}, 32'h785A);
    wait_n(2);
    rd_chk("R3 not ready before delay", 2'd0, 32'h9);
    wait_n(1);
    rd_chk("R3 ready at delay", 2'd0, 32'h109);
    rd_chk("R5 zero before settle", 2'd1, 32'h0);
    pulse_settle(2'b01, 16'h963C);
    rd_chk("R5 value captured", 2'd1, 32'h003C);
    chk("R6 applies cell value", {16'h0, code}, 32'h783C);
    wr_reg(2'd0, 32'h8);
    rd_chk("R4 ready clears after disable", 2'd0, 32'h8);
    rd_chk("R5 value held after disable", 2'd1, 32'h003C);
    chk("R6 held value applied", {16'h0, code}, 32'h783C);
  endtask

  task automatic t_no_clock();
    hsclk = 1'b0;
    wr_reg(2'd0, 32'hC); // en2, cs2
    wait_n(8);
    rd_chk("R3 no ready without clock", 2'd0, 32'hC);
    chk("R10 cell_en rail2", {30'h0, cen}, 32'h2);
    hsclk = 1'b1;
    wait_n(4);
    rd_chk("R3 ready once clock present", 2'd0, 32'h20C);
  endtask

  task automatic t_override();
    wr_reg(2'd2, 32'hA1B2);
    rd_chk("R9 ovr readback", 2'd2, 32'hA1B2);
    wr_reg(2'd0, 32'hF);
    chk("R6 override both", {16'h0, code}, 32'hA1B2);
    wr_reg(2'd0, 32'h7); // cs2=0, rail2 has no value yet
    chk("R6 rail2 fixed fallback", {16'h0, code}, 32'h5AB2);
    wait_n(4);
    rd_chk("R2 both ready", 2'd0, 32'h307);
    pulse_settle(2'b10, 16'hC4FF);
    rd_chk("R5 rail2 captured rail1 held", 2'd1, 32'hC43C);
    chk("R6 rail2 cell value", {16'h0, code}, 32'hC4B2);
  endtask

  task automatic t_standby();
    @(negedge clk); mode = 2'd3;
    #1;
    chk("R7 standby fixed code", {16'h0, code}, 32'h5A5A);
    chk("R7 standby cells off", {30'h0, cen}, 32'h0);
    rd_chk("R7 standby ready clear", 2'd0, 32'h7);
    wait_n(4);
    rd_chk("R7 standby stays clear", 2'd0, 32'h7);
  endtask

  task automatic t_stop();
    @(negedge clk); mode = 2'd2;
    #1;
    chk("R8 stop cell_en", {30'h0, cen}, 32'h1);
    wait_n(4);
    rd_chk("R8 stop rail1 ready only", 2'd0, 32'h107);
    chk("R8 stop codes", {16'h0, code}, 32'hC4B2);
    @(negedge clk); mode = 2'd1;
    #1;
    chk("R8 sleep both cells", {30'h0, cen}, 32'h3);
    @(negedge clk); mode = 2'd0;
  endtask

  task automatic t_read_only();
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_chk("R9 value word unchanged", 2'd1, 32'hC43C);
    rd_chk("R9 ovr unchanged", 2'd2, 32'hA1B2);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped reads zero", 2'd3, 32'h0);
    rd_chk("R9 unmapped write inert", 2'd2, 32'hA1B2);
    wr_reg(2'd0, 32'h300);
    rd_chk("R2 ready bits not writable", 2'd0, 32'h0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready_rail1();
    t_no_clock();
    t_override();
    t_standby();
    t_stop();
    t_read_only();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule